// File: doc/BRIEF.md
# Commit Token Arbiter with Order Recording and Replay

This block hands one commit token to one of N processors at a time, so that transactional commits happen strictly one after another in a single global order. A processor raises its request line and waits. When the arbiter grants it the token, it broadcasts its commit and then pulses its done line to give the token back. A new grant can be issued on the clock edge after the release.

The arbiter runs in one of two modes. In record mode, simultaneous requests are resolved round-robin, starting from the processor after the most recent winner. Each grant produces one byte on an outgoing record stream that names the winner. If that stream is not accepted, new grants wait, so no record is lost. In replay mode, the arbiter reads a stream of previously recorded processor IDs. It grants the token only to the processor named at the head of that stream, and only when that processor is requesting. Every other requester waits for its turn, which reproduces the recorded commit order exactly. The storage that holds the stream is outside this block.

Top module: `commit_token_arbiter`

## Requirements
- R1: At most one grant bit is high in any cycle, and a grant is issued only to a processor whose request was high in the cycle it was granted.
- R2: A grant stays high until the holder raises its own done bit; done bits from other processors are ignored. The grant drops on the edge that samples the holder's done, and another grant may be issued on the next edge.
- R3: In record mode (`replay_mode`=0), the winner among the current requesters is the first one found by searching upward from the index after the last winner, wrapping from N-1 to 0. After reset, the search starts at index 0.
- R4: In record mode, every grant loads one record. `rec_out_id` holds the winner index zero-extended to 8 bits. `rec_out_valid` is raised on the same edge as the grant and stays high until `rec_out_ready` is sampled high.
- R5: In record mode, while a record is pending and `rec_out_ready` is low, no grant is issued and the pending record stays unchanged.
- R6: In replay mode, the token goes only to the processor whose index equals `play_in_id`. It is granted when `play_in_valid` is high, that processor is requesting and the token is free. `play_in_ready` is high in exactly that cycle and consumes the entry. Other requesters are held off.
- R7: In replay mode, when `play_in_valid` is low, no grant is issued.
- R8: In replay mode, a head entry whose value is N or above sets `replay_err`. Such an entry is never consumed and grants nothing. `replay_err` stays high until reset.
- R9: Grants issued in replay mode produce no record on the outgoing stream.
- R10: While `rst` is high, all grants, `rec_out_valid`, `play_in_ready` and `replay_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| replay_mode | input | 1 | 0 = record mode, 1 = replay mode |
| req | input | N_PROC | Per-processor commit request |
| done | input | N_PROC | Per-processor token release |
| grant | output | N_PROC | Registered one-hot token grant |
| rec_out_valid | output | 1 | Outgoing record pending |
| rec_out_ready | input | 1 | Outgoing record accepted |
| rec_out_id | output | REC_W | Winner index of the pending record |
| play_in_valid | input | 1 | Replay head entry present |
| play_in_id | input | REC_W | Replay head entry: processor index |
| play_in_ready | output | 1 | Replay head entry consumed this cycle |
| replay_err | output | 1 | Sticky flag: replay entry out of range |

## Verification
A wrong round-robin pointer shows up as the wrong one-hot grant on the first contested request after the fault. A sweep over every request pattern in two passes catches it within one grant. A holder register that drops early or is never cleared is visible one edge after done, as a premature or stuck grant. A replay gate that ignores the head entry issues a grant to a deferred requester in the very cycle it should be held off. A stall that fails to hold changes `rec_out_id` on the next edge while the stream is not ready.

// File: rtl/ctarb_pkg.sv
package ctarb_pkg;
  parameter int unsigned CTARB_REC_W = 8;

  function automatic int unsigned ctarb_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ctarb_rr_pick.sv
module ctarb_rr_pick #(
  parameter int unsigned N_PROC = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [N_PROC-1:0] req,
  input  logic [IDX_W-1:0]  last_idx,
  output logic              found,
  output logic [IDX_W-1:0]  win_idx
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= int'(N_PROC); k++) begin
      int cand;
      cand = (int'(last_idx) + k) % int'(N_PROC);
      if (!found && req[cand]) begin
        found   = 1'b1;
        win_idx = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/ctarb_replay_head.sv
module ctarb_replay_head #(
  parameter int unsigned N_PROC = 4,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned REC_W  = 8
) (
  input  logic [N_PROC-1:0] req,
  input  logic [REC_W-1:0]  head_id,
  output logic              bad,
  output logic              match,
  output logic [IDX_W-1:0]  head_idx
);
  localparam logic [REC_W:0] LIMIT = (REC_W+1)'(N_PROC);

  always_comb begin
    bad      = ({1'b0, head_id} >= LIMIT);
    head_idx = head_id[IDX_W-1:0];
    match    = !bad && req[head_idx];
  end
endmodule

// File: rtl/ctarb_onehot.sv
module ctarb_onehot #(
  parameter int unsigned N_PROC = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [N_PROC-1:0] vec
);
  for (genvar g = 0; g < int'(N_PROC); g++) begin : g_bit
    assign vec[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/commit_token_arbiter.sv
module commit_token_arbiter
  import ctarb_pkg::*;
#(
  parameter int unsigned N_PROC = 4,
  parameter int unsigned REC_W  = CTARB_REC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              replay_mode,
  input  logic [N_PROC-1:0] req,
  input  logic [N_PROC-1:0] done,
  output logic [N_PROC-1:0] grant,
  output logic              rec_out_valid,
  input  logic              rec_out_ready,
  output logic [REC_W-1:0]  rec_out_id,
  input  logic              play_in_valid,
  input  logic [REC_W-1:0]  play_in_id,
  output logic              play_in_ready,
  output logic              replay_err
);
  localparam int unsigned IDX_W = ctarb_idx_w(N_PROC);
  localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(N_PROC - 1);

  logic [N_PROC-1:0] grant_q;
  logic [IDX_W-1:0]  last_q;
  logic              rec_v_q;
  logic [REC_W-1:0]  rec_id_q;
  logic              err_q;

  logic              rr_found;
  logic [IDX_W-1:0]  rr_idx;
  logic              rp_bad;
  logic              rp_match;
  logic [IDX_W-1:0]  rp_idx;
  logic [IDX_W-1:0]  sel_idx;
  logic [N_PROC-1:0] sel_vec;
  logic              busy;
  logic              released;
  logic              slot_free;
  logic              take_rr;
  logic              take_rp;

  ctarb_rr_pick #(.N_PROC(N_PROC), .IDX_W(IDX_W)) u_rr (
    .req      (req),
    .last_idx (last_q),
    .found    (rr_found),
    .win_idx  (rr_idx)
  );

  ctarb_replay_head #(.N_PROC(N_PROC), .IDX_W(IDX_W), .REC_W(REC_W)) u_head (
    .req      (req),
    .head_id  (play_in_id),
    .bad      (rp_bad),
    .match    (rp_match),
    .head_idx (rp_idx)
  );

  assign sel_idx = replay_mode ? rp_idx : rr_idx;

  ctarb_onehot #(.N_PROC(N_PROC), .IDX_W(IDX_W)) u_dec (
    .idx (sel_idx),
    .vec (sel_vec)
  );

  always_comb begin
    busy      = |grant_q;
    released  = |(grant_q & done);
    slot_free = !rec_v_q || rec_out_ready;
    take_rr   = !busy && !replay_mode && rr_found && slot_free;
    take_rp   = !busy && replay_mode && play_in_valid && rp_match;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q  <= '0;
      last_q   <= LAST_RST;
      rec_v_q  <= 1'b0;
      rec_id_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (rec_v_q && rec_out_ready) begin
        rec_v_q <= 1'b0;
      end
      if (busy) begin
        if (released) begin
          grant_q <= '0;
        end
      end else if (take_rr) begin
        grant_q  <= sel_vec;
        last_q   <= rr_idx;
        rec_v_q  <= 1'b1;
        rec_id_q <= REC_W'(rr_idx);
      end else if (take_rp) begin
        grant_q <= sel_vec;
        last_q  <= rp_idx;
      end
      if (!busy && replay_mode && play_in_valid && rp_bad) begin
        err_q <= 1'b1;
      end
    end
  end

  assign grant         = grant_q;
  assign rec_out_valid = rec_v_q;
  assign rec_out_id    = rec_id_q;
  assign play_in_ready = take_rp && !rst;
  assign replay_err    = err_q;
endmodule

// File: rtl/ctarb_checker.sv
module ctarb_checker #(
  parameter int unsigned N_PROC = 4,
  parameter int unsigned REC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              replay_mode,
  input logic [N_PROC-1:0] req,
  input logic [N_PROC-1:0] done,
  input logic [N_PROC-1:0] grant,
  input logic              rec_out_valid,
  input logic              rec_out_ready,
  input logic [REC_W-1:0]  rec_out_id,
  input logic              play_in_valid,
  input logic              play_in_ready,
  input logic              replay_err
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_grant_to_req_r1: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req != '0) |=> ((grant & ~$past(req)) == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && (grant & done) == '0) |=> (grant == $past(grant)));

  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    ((grant & done) != '0) |=> (grant == '0));

  p_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (rec_out_valid && !rec_out_ready) |=> (rec_out_valid && $stable(rec_out_id)));

  p_consume_r6: assert property (@(posedge clk) disable iff (rst)
    (play_in_valid && play_in_ready) |=> (grant != '0));

  p_sticky_err_r8: assert property (@(posedge clk) disable iff (rst)
    replay_err |=> replay_err);

  p_no_record_r9: assert property (@(posedge clk) disable iff (rst)
    (replay_mode && !rec_out_valid) |=> !rec_out_valid);
endmodule

bind commit_token_arbiter ctarb_checker #(.N_PROC(N_PROC), .REC_W(REC_W)) u_ctarb_chk (
  .clk           (clk),
  .rst           (rst),
  .replay_mode   (replay_mode),
  .req           (req),
  .done          (done),
  .grant         (grant),
  .rec_out_valid (rec_out_valid),
  .rec_out_ready (rec_out_ready),
  .rec_out_id    (rec_out_id),
  .play_in_valid (play_in_valid),
  .play_in_ready (play_in_ready),
  .replay_err    (replay_err)
);

// File: tb/tb_commit_token_arbiter.sv
`timescale 1ns/1ps
module tb_commit_token_arbiter;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         replay_mode = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] grant;
  logic         rec_out_valid;
  logic         rec_out_ready = 1'b1;
  logic [W-1:0] rec_out_id;
  logic         play_in_valid = 1'b0;
  logic [W-1:0] play_in_id = '0;
  logic         play_in_ready;
  logic         replay_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  commit_token_arbiter #(.N_PROC(N), .REC_W(W)) dut (
    .clk(clk), .rst(rst), .replay_mode(replay_mode), .req(req), .done(done),
    .grant(grant), .rec_out_valid(rec_out_valid), .rec_out_ready(rec_out_ready),
    .rec_out_id(rec_out_id), .play_in_valid(play_in_valid), .play_in_id(play_in_id),
    .play_in_ready(play_in_ready), .replay_err(replay_err)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int last;
    int win;
    int ids[5] = '{2, 0, 3, 3, 1};

    // R10: reset state
    tick(); tick();
    chk("R10 grant", int'(grant), 0);
    chk("R10 rec_out_valid", int'(rec_out_valid), 0);
    chk("R10 play_in_ready", int'(play_in_ready), 0);
    chk("R10 replay_err", int'(replay_err), 0);
    rst = 1'b0;

    // R3/R4/R1/R2: sweep every request pattern twice, round-robin model
    last = N - 1;
    for (int pass = 0; pass < 2; pass++) begin
      for (int pat = 1; pat < (1 << N); pat++) begin
        win = -1;
        for (int k = 1; k <= N; k++) begin
          int c;
          c = (last + k) % N;
          if (win < 0 && pat[c]) win = c;
        end
        req = N'(pat);
        tick();
        chk("R3 grant", int'(grant), 1 << win);
        chk("R4 rec_out_valid", int'(rec_out_valid), 1);
        chk("R4 rec_out_id", int'(rec_out_id), win);
        last = win;
        req  = '0;
        done = grant;
        tick();
        chk("R2 release", int'(grant), 0);
        chk("R4 drained", int'(rec_out_valid), 0);
        done = '0;
      end
    end

    // R5: stall while record pending and not ready
    rec_out_ready = 1'b0;
    req = 4'b0010;
    tick();
    chk("R5 first grant", int'(grant), 2);
    chk("R5 first id", int'(rec_out_id), 1);
    req = '0; done = 4'b0010;
    tick();
    done = '0;
    chk("R5 released", int'(grant), 0);
    chk("R5 pending", int'(rec_out_valid), 1);
    req = 4'b1000;
    tick();
    chk("R5 stalled grant", int'(grant), 0);
    chk("R5 stalled id", int'(rec_out_id), 1);
    tick();
    chk("R5 still stalled", int'(grant), 0);
    rec_out_ready = 1'b1;
    tick();
    chk("R5 resumed grant", int'(grant), 8);
    chk("R5 new record", int'(rec_out_valid), 1);
    chk("R5 new id", int'(rec_out_id), 3);
    req = '0; done = 4'b1000;
    tick();
    done = '0;

    // R2: done from non-holders ignored
    req = 4'b0100;
    tick();
    chk("R2 grant", int'(grant), 4);
    req = '0; done = 4'b1011;
    tick();
    chk("R2 other done ignored", int'(grant), 4);
    done = 4'b0100;
    tick();
    chk("R2 holder release", int'(grant), 0);
    done = '0;
    tick();
    chk("R4 drained before replay", int'(rec_out_valid), 0);

    // R6/R9: replay enforces the recorded order
    replay_mode = 1'b1;
    req = 4'b1111;
    foreach (ids[i]) begin
      play_in_valid = 1'b1;
      play_in_id = W'(ids[i]);
      #1;
      chk("R6 consume", int'(play_in_ready), 1);
      tick();
      chk("R6 grant order", int'(grant), 1 << ids[i]);
      chk("R9 no record", int'(rec_out_valid), 0);
      play_in_valid = 1'b0;
      done = grant;
      tick();
      chk("R2 replay release", int'(grant), 0);
      done = '0;
    end

    // R6: out-of-order requester is deferred
    req = 4'b0010;
    play_in_valid = 1'b1; play_in_id = 8'd3;
    #1;
    chk("R6 no consume", int'(play_in_ready), 0);
    tick();
    chk("R6 deferred", int'(grant), 0);
    tick();
    chk("R6 still deferred", int'(grant), 0);
    req = 4'b1010;
    #1;
    chk("R6 head ready", int'(play_in_ready), 1);
    tick();
    chk("R6 head granted", int'(grant), 8);
    play_in_valid = 1'b0; done = 4'b1000;
    tick();
    done = '0;

    // R7: empty replay stream grants nothing
    req = 4'b1111;
    tick();
    chk("R7 empty no grant", int'(grant), 0);
    tick();
    chk("R7 empty no grant again", int'(grant), 0);

    // R8: out-of-range replay entry
    play_in_valid = 1'b1; play_in_id = 8'd9;
    #1;
    chk("R8 not consumed", int'(play_in_ready), 0);
    tick();
    chk("R8 err set", int'(replay_err), 1);
    chk("R8 no grant", int'(grant), 0);
    play_in_valid = 1'b0;
    tick();
    chk("R8 err sticky", int'(replay_err), 1);
    rst = 1'b1;
    tick();
    chk("R10 err cleared", int'(replay_err), 0);
    chk("R10 grant cleared", int'(grant), 0);
    rst = 1'b0;
    req = '0;
    tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule